// File: doc/BRIEF.md
# Two-Phase Blink Output Port Controller

This block drives eight open-drain style output ports and one shared pin that serves as either an interrupt or a general-purpose output. Port levels come from one of two pattern registers. Phase A is the static pattern. Phase B is its alternate. When blinking is switched off, only phase A drives the ports. When blinking is on, the active phase is the exclusive-OR of a software flip bit and an external blink input, so either software or a hardware signal can toggle the pattern. If phase B is loaded with all ones, the blink input can release every port at once, which gates the phase A pattern in hardware.

The shared pin has two roles. In the first, it signals that the sampled port input data has changed since the last time software read it. In the second, it is a static or phase-dependent output taken from two configuration bits. Software reaches the block through a simple synchronous register port. Writes happen on a clock edge. Read data is combinational from the address.

Top module: `blink_port_ctrl`

## Requirements
- R1: Reset sets both pattern registers to 0xFF and the configuration bits to 0. As a result, every `port_oe` bit is 0 and `shared_oe` is 0.
- R2: While the enable bit (configuration bit 0) is 0, `port_oe` equals the bitwise inverse of phase A (address 0x1). Phase B, the flip bit and the blink input have no effect on the ports.
- R3: While the enable bit is 1, the active phase is flip bit (configuration bit 1) XOR the synchronized blink input. Phase 0 selects phase A and phase 1 selects phase B (address 0x9).
- R4: A pattern bit of 1 releases its port (`port_oe` bit 0, high impedance). A pattern bit of 0 drives the port low (`port_oe` bit 1).
- R5: `blink_in` passes through a two-flop synchronizer. A change at `blink_in` reaches the port outputs after the second rising clock edge, and not after the first.
- R6: When interrupt enable (configuration bit 3) is 1, `shared_oe` equals the change status: 1 drives low and 0 is high impedance.
- R7: When interrupt enable is 0 and the enable bit is 0, `shared_oe` equals configuration bit 4 (out0), and bit 5 has no effect.
- R8: When interrupt enable is 0 and the enable bit is 1, `shared_oe` equals bit 4 in phase 0 and bit 5 in phase 1.
- R9: After the first clock following reset, `port_in` is sampled on every clock edge. Any difference from the previous sample sets the change status. The status reads back as bit 7 of the configuration register (address 0xF), and writes to bit 7 are ignored.
- R10: Reading address 0x0 returns the latest port sample. A read with `rd_en` high at address 0x0 clears the change status, unless a new change arrives in the same cycle.
- R11: Pattern registers and configuration bits 6..0 read back as written at addresses 0x1, 0x9 and 0xF. Unmapped addresses read 0, and writes to them change no register.
- R12: With phase B at 0xFF and blinking enabled, moving to phase 1 through `blink_in` sets every `port_oe` bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe (clears status at address 0x0) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| port_in | input | 8 | Port input levels |
| blink_in | input | 1 | Asynchronous blink phase input |
| port_oe | output | 8 | Per-port pull-low enable (1 = drive low) |
| shared_oe | output | 1 | Shared pin pull-low enable (1 = drive low) |

## Verification
The assertions assume that `port_in` and `blink_in` are held steady during reset. They also assume that register strobes arrive with a stable address and data for the whole clock cycle. The bench drives every input on the falling edge and samples on the falling edge. It holds `port_in` constant except where a change is the point of the test, so status changes happen only where the bench expects them. `blink_in` is only toggled between register accesses, so the two-edge synchronizer delay can be observed cleanly.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_INPUT = 4'h0;
    localparam logic [ADDR_W-1:0] A_PHA   = 4'h1;
    localparam logic [ADDR_W-1:0] A_PHB   = 4'h9;
    localparam logic [ADDR_W-1:0] A_CFG   = 4'hF;

    localparam int CB_EN    = 0;
    localparam int CB_FLIP  = 1;
    localparam int CB_IE    = 3;
    localparam int CB_OUT0  = 4;
    localparam int CB_OUT1  = 5;
    localparam int SYNC_LEN = 2;

    typedef enum logic {PH_ZERO = 1'b0, PH_ONE = 1'b1} phase_e;
endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
    parameter int STAGES = bpc_pkg::SYNC_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

    // R5: output is the previous-cycle value of the stage before it
    a_r5_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_o == $past(st_q.chain[STAGES-2])));
endmodule

// File: rtl/bpc_change.sv
module bpc_change #(
    parameter int DW = bpc_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] port_in,
    input  logic          clr_i,
    output logic [DW-1:0] sample_o,
    output logic          status_o
);
    typedef struct packed {
        logic [DW-1:0] samp;
        logic          armed;
        logic          stat;
    } chg_st_t;

    chg_st_t st_d, st_q;
    logic    diff;

    always_comb begin
        diff     = st_q.armed && (port_in != st_q.samp);
        st_d     = st_q;
        st_d.samp  = port_in;
        st_d.armed = 1'b1;
        if (diff)       st_d.stat = 1'b1;
        else if (clr_i) st_d.stat = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.samp;
    assign status_o = st_q.stat;

    a_r9_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && (port_in != sample_o)) |=> status_o);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && st_q.armed && (port_in == sample_o)) |=> !status_o);
endmodule

// File: rtl/bpc_regs.sv
module bpc_regs #(
    parameter int DW = bpc_pkg::DATA_W,
    parameter int AW = bpc_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] pha_o,
    output logic [DW-1:0] phb_o,
    output logic [DW-2:0] cfg_o
);
    import bpc_pkg::*;

    typedef struct packed {
        logic [DW-1:0] pha;
        logic [DW-1:0] phb;
        logic [DW-2:0] cfg;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                A_PHA:   st_d.pha = wdata;
                A_PHB:   st_d.phb = wdata;
                A_CFG:   st_d.cfg = wdata[DW-2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pha <= '1;
            st_q.phb <= '1;
            st_q.cfg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pha_o = st_q.pha;
    assign phb_o = st_q.phb;
    assign cfg_o = st_q.cfg;

    a_r11_pha_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PHA) |=> (pha_o == $past(wdata)));

    a_r11_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG) |=> (cfg_o == $past(wdata[DW-2:0])));

    a_r11_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != A_PHA && addr != A_PHB && addr != A_CFG)
        |=> ($stable(pha_o) && $stable(phb_o) && $stable(cfg_o)));
endmodule

// File: rtl/blink_port_ctrl.sv
module blink_port_ctrl #(
    parameter int DW = bpc_pkg::DATA_W,
    parameter int AW = bpc_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] port_in,
    input  logic          blink_in,
    output logic [DW-1:0] port_oe,
    output logic          shared_oe
);
    import bpc_pkg::*;

    logic [DW-1:0] pha, phb, samp;
    logic [DW-2:0] cfg;
    logic          blink_s, status, rd_clr;
    phase_e        phase;

    bpc_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pha_o(pha), .phb_o(phb), .cfg_o(cfg)
    );

    bpc_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(blink_in), .sync_o(blink_s)
    );

    assign rd_clr = rd_en && (addr == A_INPUT);

    bpc_change #(.DW(DW)) u_chg (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .clr_i(rd_clr),
        .sample_o(samp), .status_o(status)
    );

    always_comb begin
        phase = (cfg[CB_EN] && (cfg[CB_FLIP] ^ blink_s)) ? PH_ONE : PH_ZERO;
        port_oe = (phase == PH_ONE) ? ~phb : ~pha;
        if (cfg[CB_IE])            shared_oe = status;
        else if (phase == PH_ONE)  shared_oe = cfg[CB_OUT1];
        else                       shared_oe = cfg[CB_OUT0];
    end

    always_comb begin
        unique case (addr)
            A_INPUT: rdata = samp;
            A_PHA:   rdata = pha;
            A_PHB:   rdata = phb;
            A_CFG:   rdata = {status, cfg};
            default: rdata = '0;
        endcase
    end

    // R2: with blinking off and phase A unchanged, ports hold still
    a_r2_phb_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cfg[CB_EN] && !$past(cfg[CB_EN]) && $stable(pha))
        |-> $stable(port_oe));
endmodule

// File: tb/blink_port_ctrl_tb.sv
module blink_port_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] port_in = 8'h00;
    logic       blink_in = 1'b0;
    logic [7:0] port_oe;
    logic       shared_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    blink_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .port_in(port_in), .blink_in(blink_in),
        .port_oe(port_oe), .shared_oe(shared_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_blink(input logic v);
        @(negedge clk);
        blink_in = v;
        cyc(2);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 port_oe", port_oe, 8'h00);
        chk("R1 shared_oe", {7'b0, shared_oe}, 8'h00);
        peek(4'h1, v); chk("R1 phase A", v, 8'hFF);
        peek(4'h9, v); chk("R1 phase B", v, 8'hFF);
        peek(4'hF, v); chk("R1 cfg", v, 8'h00);
    endtask

    task automatic t_disabled();
        wr(4'h1, 8'hA5);
        wr(4'h9, 8'h3C);
        chk("R4 R2 polarity", port_oe, 8'h5A);
        wr(4'hF, 8'h02);
        set_blink(1'b1);
        cyc(1);
        chk("R2 flip and blink ignored", port_oe, 8'h5A);
        set_blink(1'b0);
    endtask

    task automatic t_enabled();
        wr(4'hF, 8'h01);
        chk("R3 phase0", port_oe, 8'h5A);
        wr(4'hF, 8'h03);
        chk("R3 flip selects phase B", port_oe, 8'hC3);
        @(negedge clk);
        blink_in = 1'b1;
        @(negedge clk);
        chk("R5 not after one edge", port_oe, 8'hC3);
        @(negedge clk);
        chk("R5 R3 after two edges xor", port_oe, 8'h5A);
        wr(4'hF, 8'h01);
        chk("R3 blink alone phase B", port_oe, 8'hC3);
        set_blink(1'b0);
        chk("R3 back to phase A", port_oe, 8'h5A);
    endtask

    task automatic t_gate();
        wr(4'h9, 8'hFF);
        wr(4'hF, 8'h01);
        chk("R12 phase A shown", port_oe, 8'h5A);
        set_blink(1'b1);
        chk("R12 all released", port_oe, 8'h00);
        set_blink(1'b0);
        chk("R12 restored", port_oe, 8'h5A);
    endtask

    task automatic t_shared();
        wr(4'hF, 8'h10);
        chk("R7 out0 high", {7'b0, shared_oe}, 8'h01);
        wr(4'hF, 8'h20);
        chk("R7 out1 ignored", {7'b0, shared_oe}, 8'h00);
        wr(4'hF, 8'h21);
        chk("R8 phase0 uses out0", {7'b0, shared_oe}, 8'h00);
        set_blink(1'b1);
        chk("R8 phase1 uses out1", {7'b0, shared_oe}, 8'h01);
        wr(4'hF, 8'h11);
        chk("R8 phase1 out1 zero", {7'b0, shared_oe}, 8'h00);
        set_blink(1'b0);
        chk("R8 phase0 out0 one", {7'b0, shared_oe}, 8'h01);
    endtask

    task automatic t_interrupt();
        logic [7:0] v;
        wr(4'hF, 8'h08);
        chk("R6 no change idle", {7'b0, shared_oe}, 8'h00);
        @(negedge clk);
        port_in = 8'h3C;
        @(negedge clk);
        chk("R6 change pulls low", {7'b0, shared_oe}, 8'h01);
        peek(4'hF, v); chk("R9 status readback", v, 8'h88);
        wr(4'hF, 8'h08);
        peek(4'hF, v); chk("R9 write bit7 ignored", v, 8'h88);
        peek(4'h0, v); chk("R10 sample readback", v, 8'h3C);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'h0;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R10 read clears", {7'b0, shared_oe}, 8'h00);
        peek(4'hF, v); chk("R10 cfg after clear", v, 8'h08);
        wr(4'hF, 8'h00);
        @(negedge clk);
        port_in = 8'h3D;
        @(negedge clk);
        chk("R9 status hidden when ie off", {7'b0, shared_oe}, 8'h00);
        peek(4'hF, v); chk("R9 status set while ie off", v, 8'h80);
    endtask

    task automatic t_map();
        logic [7:0] v;
        wr(4'h5, 8'h00);
        peek(4'h5, v); chk("R11 unmapped reads zero", v, 8'h00);
        peek(4'h1, v); chk("R11 phase A kept", v, 8'hA5);
        peek(4'h9, v); chk("R11 phase B kept", v, 8'hFF);
        wr(4'hF, 8'h7E);
        peek(4'hF, v); chk("R11 cfg low bits", v, 8'hFE);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_disabled();
        t_enabled();
        t_gate();
        t_shared();
        t_interrupt();
        t_map();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule